// File: doc/BRIEF.md
# Nibble-Coded 8-bit Multicycle Processor

This block is a small processor core with sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. Every instruction is one 16-bit word made of four 4-bit fields. The top field selects the operation. The core fetches the word as two byte reads, decodes it, and executes it in a fixed sequence of states. Memory loads take one extra state.

One synchronous byte memory port serves both instruction fetches and data accesses. The port carries an address, write data, read data, a read strobe and a write strobe. Read data is taken in the cycle after the read strobe. Operations are load from memory, load immediate, move, store, integer add, OR, AND, XOR, rotate right, jump when a register is zero, and halt. When the core stops it raises a status output and holds it until reset.

Top module: `nib_cpu`

## Requirements
- R1: While reset is high, PC and all sixteen registers clear to zero. In the first cycle after reset the core drives a read of address 0x00, with the write strobe low and `halted` low.
- R2: Fetch reads the byte at PC into IR bits 15:8 and the byte at PC+1 into IR bits 7:0, then adds 2 to PC. IR bits 15:12 are the opcode, bits 11:8 are field A, bits 7:4 are field B and bits 3:0 are field C. A non-load instruction takes four cycles and a memory load takes five.
- R3: Opcode 0x1 loads register A from the memory byte addressed by IR bits 7:0. Opcode 0x2 loads register A with IR bits 7:0 as the value.
- R4: Opcode 0x3 writes register A to the memory byte addressed by IR bits 7:0.
- R5: Opcode 0x4 copies register B into register C. Field A has no effect.
- R6: Opcode 0x5 writes the 8-bit sum of registers B and C into register A. The carry is discarded.
- R7: Opcode 0x7 writes B OR C into register A. Opcode 0x8 writes B AND C into register A. Opcode 0x9 writes B XOR C into register A.
- R8: Opcode 0xA rotates register A right in place by field C modulo 8 positions. Field B has no effect. Bits leaving bit 0 re-enter at bit 7.
- R9: Opcode 0xB loads PC with IR bits 7:0 when register A is zero. Otherwise execution continues at the next word.
- R10: Opcode 0xC raises `halted`. From then until reset the core makes no memory read or write and `halted` stays high.
- R11: Opcodes 0x0, 0x6, 0xD, 0xE and 0xF change no register and no memory byte.
- R12: The core never asserts read and write in the same cycle. A byte written by a store is seen by the fetch that immediately follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Byte address for fetch, load or store |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The store write and the instruction fetch that follows it meet on one memory byte in back-to-back cycles. The bench provokes this with a store that overwrites the first byte of the next instruction, turning that instruction into a halt. It judges the result at the ports: `halted` is high and a sentinel byte is untouched, which the original store would have overwritten. Broad sweeps of operand pairs and of rotate counts 0 to 15 cover the arithmetic. Directed programs cover jumps, no-op codes, reset clearing and the freeze after halt.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int NREG    = 16;
    localparam int RSEL_W  = $clog2(NREG);
    localparam int IW      = 2 * DW;

    typedef enum logic [3:0] {
        OP_NOP0 = 4'h0, OP_LDM  = 4'h1, OP_LDI  = 4'h2, OP_ST   = 4'h3,
        OP_MOV  = 4'h4, OP_ADD  = 4'h5, OP_FADD = 4'h6, OP_OR   = 4'h7,
        OP_AND  = 4'h8, OP_XOR  = 4'h9, OP_ROR  = 4'hA, OP_JZ   = 4'hB,
        OP_HLT  = 4'hC, OP_RSVD = 4'hD, OP_RSVE = 4'hE, OP_RSVF = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_F0, ST_F1, ST_F2, ST_EX, ST_LD, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_OR, ALU_AND, ALU_XOR, ALU_PASS, ALU_ROR
    } alu_e;

    typedef struct packed {
        opcode_e     op;
        logic [3:0]  fa;
        logic [3:0]  fb;
        logic [3:0]  fc;
    } instr_t;

    function automatic logic [DW-1:0] rotr(input logic [DW-1:0] v, input logic [3:0] n);
        logic [2*DW-1:0] d;
        d = {v, v} >> (int'(n) % DW);
        return d[DW-1:0];
    endfunction

    function automatic alu_e alu_for(input opcode_e op);
        case (op)
            OP_ADD:  return ALU_ADD;
            OP_OR:   return ALU_OR;
            OP_AND:  return ALU_AND;
            OP_XOR:  return ALU_XOR;
            OP_ROR:  return ALU_ROR;
            default: return ALU_PASS;
        endcase
    endfunction

endpackage

// File: rtl/nib_cpu_regfile.sv
module nib_cpu_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] ra,
    input  logic [SW-1:0] rb,
    input  logic [SW-1:0] wa,
    input  logic          we,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] qa,
    output logic [DW-1:0] qb
);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];

endmodule

// File: rtl/nib_cpu_alu.sv
module nib_cpu_alu
    import nib_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   cnt,
    output logic [W-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD: y = W'(a + b);
            ALU_OR:  y = a | b;
            ALU_AND: y = a & b;
            ALU_XOR: y = a ^ b;
            ALU_ROR: y = rotr(a, cnt);
            default: y = a;
        endcase
    end

    // R8: a rotation keeps the number of set bits
    always_comb begin
        if (op == ALU_ROR)
            a_r8_rot_keeps_ones: assert ($countones(y) == $countones(a));
    end

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
    import nib_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          halted
);

    state_e          state_q;
    logic [AW-1:0]   pc_q;
    logic [IW-1:0]   ir_q;
    instr_t          ins;
    logic [DW-1:0]   imm;

    logic [RSEL_W-1:0] ra_sel, rb_sel, wa_sel;
    logic              rf_we;
    logic [DW-1:0]     rf_wd, qa, qb, alu_y;
    alu_e              alu_op;

    assign ins = instr_t'(ir_q);
    assign imm = {ins.fb, ins.fc};

    nib_cpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra(ra_sel), .rb(rb_sel), .wa(wa_sel),
        .we(rf_we), .wd(rf_wd), .qa(qa), .qb(qb)
    );

    nib_cpu_alu #(.W(DW)) u_alu (
        .op(alu_op), .a(qa), .b(qb), .cnt(ins.fc), .y(alu_y)
    );

    // operand routing and register write-back
    always_comb begin
        ra_sel = ins.fb;
        rb_sel = ins.fc;
        wa_sel = ins.fa;
        rf_we  = 1'b0;
        rf_wd  = alu_y;
        alu_op = alu_for(ins.op);
        if (state_q == ST_LD) begin
            rf_we = 1'b1;
            rf_wd = mem_rdata;
        end else if (state_q == ST_EX) begin
            case (ins.op)
                OP_LDI: begin
                    rf_we = 1'b1;
                    rf_wd = imm;
                end
                OP_MOV: begin
                    wa_sel = ins.fc;
                    rf_we  = 1'b1;
                end
                OP_ADD, OP_OR, OP_AND, OP_XOR: rf_we = 1'b1;
                OP_ROR: begin
                    ra_sel = ins.fa;
                    rf_we  = 1'b1;
                end
                OP_ST, OP_JZ: ra_sel = ins.fa;
                default: ;
            endcase
        end
    end

    // memory port
    always_comb begin
        mem_addr  = pc_q;
        mem_wdata = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        case (state_q)
            ST_F0: mem_rd = 1'b1;
            ST_F1: begin
                mem_rd   = 1'b1;
                mem_addr = AW'(pc_q + 1'b1);
            end
            ST_EX: begin
                if (ins.op == OP_LDM) begin
                    mem_rd   = 1'b1;
                    mem_addr = imm;
                end else if (ins.op == OP_ST) begin
                    mem_wr    = 1'b1;
                    mem_addr  = imm;
                    mem_wdata = qa;
                end
            end
            default: ;
        endcase
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_F0;
            pc_q    <= '0;
            ir_q    <= '0;
        end else begin
            case (state_q)
                ST_F0: state_q <= ST_F1;
                ST_F1: begin
                    ir_q[IW-1:DW] <= mem_rdata;
                    state_q       <= ST_F2;
                end
                ST_F2: begin
                    ir_q[DW-1:0] <= mem_rdata;
                    pc_q         <= AW'(pc_q + 2'd2);
                    state_q      <= ST_EX;
                end
                ST_EX: begin
                    case (ins.op)
                        OP_LDM: state_q <= ST_LD;
                        OP_HLT: state_q <= ST_HALT;
                        OP_JZ: begin
                            if (qa == '0) pc_q <= imm;
                            state_q <= ST_F0;
                        end
                        default: state_q <= ST_F0;
                    endcase
                end
                ST_LD:   state_q <= ST_F0;
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign halted = (state_q == ST_HALT);

    a_r1_boot_fetch: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_rd && !mem_wr && mem_addr == '0 && !halted));

    a_r2_fetch_pair: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_F1) |-> (mem_rd && mem_addr == AW'($past(mem_addr) + 1'b1)));

    a_r3_load_follows_read: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LD) |-> $past(mem_rd));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

// File: tb/nib_cpu_test.sv
module nib_cpu_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_rd, mem_wr, halted;

    logic       ld_en = 1'b0;
    logic [7:0] ld_a  = '0;
    logic [7:0] ld_d  = '0;
    logic [7:0] ram [256];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_cpu uut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
    );

    // byte memory model: one-cycle read latency
    always @(posedge clk) begin
        if (ld_en) ram[ld_a] <= ld_d;
        else if (mem_wr) ram[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic poke16(input logic [7:0] a, input logic [15:0] w);
        poke(a, w[15:8]);
        poke(8'(a + 1), w[7:0]);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
    endtask

    task automatic run(output int cyc);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        check(halted, "R10 halt reached", int'(halted), 1);
    endtask

    function automatic int ror_ref(input int v, input int n);
        int s;
        s = n % 8;
        return ((v >> s) | (v << (8 - s))) & 8'hFF;
    endfunction

    function automatic logic [7:0] val_of(input int i, input int k);
        if (i == 15) return 8'hFF;
        return 8'((i * k) & 8'hFF);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;

        // R1: reset state seen at the ports
        hold_reset();
        poke16(8'h00, 16'hC000);
        rst = 1'b0;
        #1;
        check(mem_rd && mem_addr == 8'h00, "R1 first fetch at 0", int'(mem_addr), 0);
        check(!mem_wr && !halted, "R1 no write, not halted", int'({mem_wr, halted}), 0);
        run(cyc);

        // R2 R3 R4 R6 R9: worked example reached through a taken jump
        hold_reset();
        poke16(8'h00, 16'hB0A0);
        poke16(8'hA0, 16'h156C);
        poke16(8'hA2, 16'h166D);
        poke16(8'hA4, 16'h5056);
        poke16(8'hA6, 16'h306E);
        poke16(8'hA8, 16'hC000);
        poke(8'h6C, 8'h2A); poke(8'h6D, 8'hF1); poke(8'h6E, 8'h00);
        run(cyc);
        check(ram[8'h6E] == 8'h1B, "R6 example sum with carry dropped", int'(ram[8'h6E]), 'h1B);

        // R3 R5 R11: load immediate, move, no-op codes; R2 cycle count
        hold_reset();
        poke16(8'h00, 16'h235A);
        poke16(8'h02, 16'h4F34);
        poke16(8'h04, 16'h34F0);
        poke16(8'h06, 16'h33F1);
        poke16(8'h08, 16'h2233);
        poke16(8'h0A, 16'h6222);
        poke16(8'h0C, 16'h0222);
        poke16(8'h0E, 16'hD2F3);
        poke16(8'h10, 16'hE2F3);
        poke16(8'h12, 16'hF2F3);
        poke16(8'h14, 16'h32F2);
        poke16(8'h16, 16'hC000);
        poke(8'hF0, 8'h00); poke(8'hF1, 8'h00); poke(8'hF2, 8'h00); poke(8'hF3, 8'h00);
        run(cyc);
        check(ram[8'hF0] == 8'h5A, "R5 move into C", int'(ram[8'hF0]), 'h5A);
        check(ram[8'hF1] == 8'h5A, "R5 move source kept", int'(ram[8'hF1]), 'h5A);
        check(ram[8'hF2] == 8'h33, "R11 no-op kept register", int'(ram[8'hF2]), 'h33);
        check(ram[8'hF3] == 8'h00, "R11 no-op wrote no memory", int'(ram[8'hF3]), 0);
        check(cyc == 48, "R2 four cycles per instruction", cyc, 48);

        // R10: frozen after halt
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(halted && !mem_rd && !mem_wr, "R10 frozen after halt",
                  int'({halted, mem_rd, mem_wr}), 4);
        end

        // R9: not-taken and taken jump
        hold_reset();
        poke16(8'h00, 16'h2101);
        poke16(8'h02, 16'hB10A);
        poke16(8'h04, 16'h2277);
        poke16(8'h06, 16'hB00C);
        poke16(8'h08, 16'h2288);
        poke16(8'h0A, 16'h2299);
        poke16(8'h0C, 16'h32F0);
        poke16(8'h0E, 16'hC000);
        poke(8'hF0, 8'h00);
        run(cyc);
        check(ram[8'hF0] == 8'h77, "R9 jump taken only on zero", int'(ram[8'hF0]), 'h77);

        // R12: store rewrites the next fetched instruction into a halt
        hold_reset();
        poke16(8'h00, 16'h20C0);
        poke16(8'h02, 16'h3004);
        poke16(8'h04, 16'h31F0);
        poke16(8'h06, 16'hC000);
        poke(8'hF0, 8'hEE);
        run(cyc);
        check(ram[8'hF0] == 8'hEE, "R12 store seen by next fetch", int'(ram[8'hF0]), 'hEE);

        // R3 R4 R6 R7 R8: sweep over operand pairs and rotate counts
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [7:0] a, b;
                int e_add, e_or, e_and, e_xor, e_rot;
                a = val_of(i, 37);
                b = val_of(j, 91);
                e_add = (int'(a) + int'(b)) & 8'hFF;
                e_or  = int'(a | b);
                e_and = int'(a & b);
                e_xor = int'(a ^ b);
                e_rot = ror_ref(int'(a), j);
                hold_reset();
                poke16(8'h00, 16'h1580);
                poke16(8'h02, 16'h1681);
                poke16(8'h04, 16'h5756);
                poke16(8'h06, 16'h7856);
                poke16(8'h08, 16'h8956);
                poke16(8'h0A, 16'h9A56);
                poke16(8'h0C, 16'h3790);
                poke16(8'h0E, 16'h3891);
                poke16(8'h10, 16'h3992);
                poke16(8'h12, 16'h3A93);
                poke16(8'h14, {8'hA5, 4'(i), 4'(j)});
                poke16(8'h16, 16'h3594);
                poke16(8'h18, 16'hC000);
                poke(8'h80, a); poke(8'h81, b);
                poke(8'h90, 8'(~e_add)); poke(8'h91, 8'(~e_or));
                poke(8'h92, 8'(~e_and)); poke(8'h93, 8'(~e_xor));
                poke(8'h94, 8'(~e_rot));
                run(cyc);
                check(int'(ram[8'h90]) == e_add, "R6 add via loaded operands", int'(ram[8'h90]), e_add);
                check(int'(ram[8'h91]) == e_or,  "R7 or",  int'(ram[8'h91]), e_or);
                check(int'(ram[8'h92]) == e_and, "R7 and", int'(ram[8'h92]), e_and);
                check(int'(ram[8'h93]) == e_xor, "R7 xor", int'(ram[8'h93]), e_xor);
                check(int'(ram[8'h94]) == e_rot, "R8 rotate by count", int'(ram[8'h94]), e_rot);
                // R3 load cost: 2 loads at 5, 11 others at 4 cycles
                check(cyc == 54, "R3 load takes five cycles", cyc, 54);
            end
        end

        // R1: registers cleared by a new reset
        hold_reset();
        poke16(8'h00, 16'h35F0);
        poke16(8'h02, 16'h3AF1);
        poke16(8'h04, 16'hC000);
        poke(8'hF0, 8'hFF); poke(8'hF1, 8'hFF);
        run(cyc);
        check(ram[8'hF0] == 8'h00, "R1 register cleared by reset", int'(ram[8'hF0]), 0);
        check(ram[8'hF1] == 8'h00, "R1 register cleared by reset", int'(ram[8'hF1]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule